// File: doc/BRIEF.md
# Integer Compare-and-Set-Predicate Unit

This execution unit carries out one integer compare-and-set-predicate instruction per accepted issue. An issue presents a 64-bit instruction word, operand A (already read from the general register named by the instruction) and operand B (supplied by the caller from a register, a 20-bit immediate or a constant buffer). The unit compares the two 32-bit operands, as signed or unsigned numbers, under one of eight conditions. It then merges the outcome, and separately its complement, with a source predicate that may be inverted. The two merged bits are written to two destination entries of a local eight-entry predicate file.

Results are registered: one clock after an accepted issue the unit raises a done pulse and presents both merged bits. From that cycle on, the predicate file holds the new values. A following issue in the next cycle therefore already sees them as its source. A reserved merge code marks the instruction as illegal and leaves the predicate file untouched. A read port lets the surrounding pipeline observe any predicate entry.

Top module: `icmp_pset_unit`

## Requirements
- R1: The condition field is instruction bits [51:49]: 0 never, 1 A<B, 2 A==B, 3 A<=B, 4 A>B, 5 A!=B, 6 A>=B, 7 always.
- R2: Instruction bit 48 set makes the ordering conditions treat operands as two's complement; clear makes them unsigned. Conditions 2 and 5 do not depend on bit 48.
- R3: The merge field is bits [46:45] (0 AND, 1 OR, 2 XOR). The source predicate index is bits [41:39]; bit 42 set inverts its value before the merge.
- R4: The predicate indexed by bits [5:3] receives merge(compare, source) and the one indexed by bits [2:0] receives merge(not compare, source); res_a_o and res_b_o show these two bits.
- R5: Merge code 3 raises illegal_o together with done_o and writes no predicate; legal codes leave illegal_o low.
- R6: The predicate file has 8 entries; entries 0 to 6 reset to false; entry 7 always reads true and ignores writes.
- R7: When both destination indices are equal, that entry takes the value meant for the bits [5:3] destination.
- R8: done_o pulses in the single cycle after each accepted issue (issue_valid and issue_ready high at a clock edge), never otherwise; the predicate file shows the new values from that cycle, so a back-to-back issue reads them.
- R9: areg_idx is instruction bits [15:8], combinationally, so operand A can be read in the issue cycle.
- R10: During reset and until two clocks after its release issue_ready and done_o are low; after that issue_ready stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_valid | input | 1 | Instruction presented |
| issue_ready | output | 1 | Unit accepts an instruction |
| issue_insn | input | 64 | Instruction word |
| areg_idx | output | 8 | General register index for operand A |
| opnd_a | input | 32 | Operand A value |
| opnd_b | input | 32 | Operand B value |
| done_o | output | 1 | Write-back pulse |
| illegal_o | output | 1 | Reserved merge code seen (valid with done_o) |
| res_a_o | output | 1 | Bit written to destination A |
| res_b_o | output | 1 | Bit written to destination B |
| prd_idx | input | 3 | Predicate observe index |
| prd_val | output | 1 | Value of the observed predicate |

## Verification
The assertions take for granted that the issue inputs are known at every clock edge once reset is released and that operands belong to the instruction presented in the same cycle. The predicate-stability checks only judge cycles in which the observe index is held, so they assume the caller changes it between, not across, the cycles they cover. The bench drives every input on the falling edge, holds the observe index constant around each issue and only samples outputs one falling edge after the accepting rising edge.

// File: rtl/icmp_pset_pkg.sv
package icmp_pset_pkg;

  localparam int INSN_W   = 64;
  localparam int PRED_N   = 8;
  localparam int PIDX_W   = $clog2(PRED_N);
  localparam int AREG_W   = 8;

  localparam int F_DSTB   = 0;
  localparam int F_DSTA   = 3;
  localparam int F_AREG   = 8;
  localparam int F_SRCP   = 39;
  localparam int F_SNEG   = 42;
  localparam int F_MERGE  = 45;
  localparam int F_SIGN   = 48;
  localparam int F_COND   = 49;

  typedef enum logic [2:0] {
    COND_NEVER = 3'd0,
    COND_LT    = 3'd1,
    COND_EQ    = 3'd2,
    COND_LE    = 3'd3,
    COND_GT    = 3'd4,
    COND_NE    = 3'd5,
    COND_GE    = 3'd6,
    COND_ALWAYS= 3'd7
  } cond_e;

  typedef enum logic [1:0] {
    MERGE_AND  = 2'd0,
    MERGE_OR   = 2'd1,
    MERGE_XOR  = 2'd2,
    MERGE_RSVD = 2'd3
  } merge_e;

  typedef struct packed {
    cond_e               cond;
    logic                is_signed;
    merge_e              merge;
    logic [PIDX_W-1:0]   src_idx;
    logic                src_inv;
    logic [PIDX_W-1:0]   dst_a;
    logic [PIDX_W-1:0]   dst_b;
    logic [AREG_W-1:0]   areg;
  } ctl_t;

endpackage

// File: rtl/icmp_pset_decode.sv
module icmp_pset_decode
  import icmp_pset_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output ctl_t              ctl
);

  logic unused_insn_bits;

  always_comb begin
    ctl.cond      = cond_e'(insn[F_COND +: 3]);
    ctl.is_signed = insn[F_SIGN];
    ctl.merge     = merge_e'(insn[F_MERGE +: 2]);
    ctl.src_idx   = insn[F_SRCP +: PIDX_W];
    ctl.src_inv   = insn[F_SNEG];
    ctl.dst_a     = insn[F_DSTA +: PIDX_W];
    ctl.dst_b     = insn[F_DSTB +: PIDX_W];
    ctl.areg      = insn[F_AREG +: AREG_W];
  end

  assign unused_insn_bits = ^{insn[INSN_W-1:F_COND+3], insn[F_MERGE+2 +: 1],
                              insn[F_SNEG+1 +: 2], insn[F_SRCP-1:F_AREG+AREG_W],
                              insn[F_AREG-1:F_DSTA+PIDX_W]};

endmodule

// File: rtl/icmp_pset_compare.sv
module icmp_pset_compare
  import icmp_pset_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  cond_e             cond,
  input  logic              is_signed,
  output logic              hit
);

  logic lt_s, lt_u, lt, eq;

  always_comb begin
    lt_u = (a < b);
    lt_s = ($signed(a) < $signed(b));
    lt   = is_signed ? lt_s : lt_u;
    eq   = (a == b);
    unique case (cond)
      COND_NEVER:  hit = 1'b0;
      COND_LT:     hit = lt;
      COND_EQ:     hit = eq;
      COND_LE:     hit = lt | eq;
      COND_GT:     hit = ~(lt | eq);
      COND_NE:     hit = ~eq;
      COND_GE:     hit = ~lt;
      COND_ALWAYS: hit = 1'b1;
      default:     hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/icmp_pset_merge.sv
module icmp_pset_merge
  import icmp_pset_pkg::*;
(
  input  logic   hit,
  input  logic   src_raw,
  input  logic   src_inv,
  input  merge_e merge,
  output logic   out_a,
  output logic   out_b,
  output logic   legal
);

  logic src;

  always_comb begin
    src   = src_raw ^ src_inv;
    legal = 1'b1;
    unique case (merge)
      MERGE_AND: begin out_a = hit & src;   out_b = ~hit & src;   end
      MERGE_OR:  begin out_a = hit | src;   out_b = ~hit | src;   end
      MERGE_XOR: begin out_a = hit ^ src;   out_b = ~hit ^ src;   end
      default:   begin out_a = 1'b0; out_b = 1'b0; legal = 1'b0; end
    endcase
  end

endmodule

// File: rtl/icmp_pset_predfile.sv
module icmp_pset_predfile
  import icmp_pset_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [PIDX_W-1:0] wa_idx,
  input  logic              wa_val,
  input  logic [PIDX_W-1:0] wb_idx,
  input  logic              wb_val,
  input  logic [PIDX_W-1:0] src_idx,
  output logic              src_val,
  input  logic [PIDX_W-1:0] obs_idx,
  output logic              obs_val
);

  logic [PRED_N-1:0] pred;

  for (genvar i = 0; i < PRED_N - 1; i++) begin : g_entry
    logic ent_q, ent_d, ent_en;

    always_comb begin
      ent_en = wen && ((wa_idx == PIDX_W'(i)) || (wb_idx == PIDX_W'(i)));
      ent_d  = (wa_idx == PIDX_W'(i)) ? wa_val : wb_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= 1'b0;
      else if (ent_en) ent_q <= ent_d;
    end

    assign pred[i] = ent_q;
  end

  assign pred[PRED_N-1] = 1'b1;

  assign src_val = pred[src_idx];
  assign obs_val = pred[obs_idx];

endmodule

// File: rtl/icmp_pset_unit.sv
module icmp_pset_unit
  import icmp_pset_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic [INSN_W-1:0] issue_insn,
  output logic [AREG_W-1:0] areg_idx,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              done_o,
  output logic              illegal_o,
  output logic              res_a_o,
  output logic              res_b_o,
  input  logic [PIDX_W-1:0] prd_idx,
  output logic              prd_val
);

  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;

  ctl_t ctl;
  logic fire, hit, src_raw, out_a, out_b, legal, wen;

  logic done_q, done_d;
  logic ill_q, ill_d;
  logic ra_q, ra_d, rb_q, rb_d;
  logic res_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n   = rst_pipe_q[RST_STAGES-1];
  assign issue_ready = rst_int_n;

  icmp_pset_decode u_dec (
    .insn (issue_insn),
    .ctl  (ctl)
  );

  assign areg_idx = ctl.areg;
  assign fire     = issue_valid && issue_ready;

  icmp_pset_compare #(.DATA_W(DATA_W)) u_cmp (
    .a         (opnd_a),
    .b         (opnd_b),
    .cond      (ctl.cond),
    .is_signed (ctl.is_signed),
    .hit       (hit)
  );

  icmp_pset_merge u_mrg (
    .hit     (hit),
    .src_raw (src_raw),
    .src_inv (ctl.src_inv),
    .merge   (ctl.merge),
    .out_a   (out_a),
    .out_b   (out_b),
    .legal   (legal)
  );

  assign wen = fire && legal;

  icmp_pset_predfile u_pf (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wen     (wen),
    .wa_idx  (ctl.dst_a),
    .wa_val  (out_a),
    .wb_idx  (ctl.dst_b),
    .wb_val  (out_b),
    .src_idx (ctl.src_idx),
    .src_val (src_raw),
    .obs_idx (prd_idx),
    .obs_val (prd_val)
  );

  always_comb begin
    done_d = fire;
    res_en = fire;
    ill_d  = ~legal;
    ra_d   = out_a;
    rb_d   = out_b;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) done_q <= 1'b0;
    else            done_q <= done_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ill_q <= 1'b0;
      ra_q  <= 1'b0;
      rb_q  <= 1'b0;
    end else if (res_en) begin
      ill_q <= ill_d;
      ra_q  <= ra_d;
      rb_q  <= rb_d;
    end
  end

  assign done_o    = done_q;
  assign illegal_o = done_q & ill_q;
  assign res_a_o   = ra_q;
  assign res_b_o   = rb_q;

endmodule

// File: rtl/icmp_pset_chk.sv
module icmp_pset_chk
  import icmp_pset_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              issue_valid,
  input logic              issue_ready,
  input logic [INSN_W-1:0] issue_insn,
  input logic              done_o,
  input logic              illegal_o,
  input logic              res_a_o,
  input logic              res_b_o,
  input logic [PIDX_W-1:0] prd_idx,
  input logic              prd_val
);

  logic acc;
  assign acc = issue_valid && issue_ready;

  AST_DONE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> done_o); // R8
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !done_o); // R8
  AST_IDLE_PRED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> (!$stable(prd_idx) || $stable(prd_val))); // R8
  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && issue_insn[F_MERGE +: 2] == 2'd3) |=> illegal_o); // R5
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && issue_insn[F_MERGE +: 2] == 2'd3) |=> (!$stable(prd_idx) || $stable(prd_val))); // R5
  AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> done_o); // R5
  AST_TOP_PRED_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_idx == PIDX_W'(PRED_N-1)) |-> prd_val); // R6
  AST_AND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(issue_insn[F_MERGE +: 2]) == 2'd0) |-> !(res_a_o && res_b_o)); // R4
  AST_OR_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(issue_insn[F_MERGE +: 2]) == 2'd1) |-> (res_a_o || res_b_o)); // R4
  AST_XOR_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(issue_insn[F_MERGE +: 2]) == 2'd2) |-> (res_a_o != res_b_o)); // R4

endmodule

bind icmp_pset_unit icmp_pset_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .issue_ready (issue_ready),
  .issue_insn  (issue_insn),
  .done_o      (done_o),
  .illegal_o   (illegal_o),
  .res_a_o     (res_a_o),
  .res_b_o     (res_b_o),
  .prd_idx     (prd_idx),
  .prd_val     (prd_val)
);

// File: tb/icmp_pset_unit_tb_top.sv
`timescale 1ns/1ps
module icmp_pset_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid;
  logic        issue_ready;
  logic [63:0] issue_insn;
  logic [7:0]  areg_idx;
  logic [31:0] opnd_a, opnd_b;
  logic        done_o, illegal_o, res_a_o, res_b_o;
  logic [2:0]  prd_idx;
  logic        prd_val;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  icmp_pset_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_insn(issue_insn), .areg_idx(areg_idx),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .done_o(done_o), .illegal_o(illegal_o),
    .res_a_o(res_a_o), .res_b_o(res_b_o),
    .prd_idx(prd_idx), .prd_val(prd_val)
  );

  // operand pair, then expected signed-less, unsigned-less, equal
  localparam logic [66:0] VEC [10] = '{
    {32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 1'b1},
    {32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0},
    {32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0, 1'b0},
    {32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0},
    {32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 1'b1, 1'b0},
    {32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 1'b1},
    {32'h0000_0005, 32'h0000_0009, 1'b1, 1'b1, 1'b0},
    {32'h1234_5678, 32'h1234_5677, 1'b0, 1'b0, 1'b0},
    {32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0},
    {32'h8000_0000, 32'h0000_0000, 1'b1, 1'b0, 1'b0}
  };

  function automatic logic [63:0] mk(input logic [2:0] cc, input logic sg,
      input logic [1:0] mg, input logic ng, input logic [2:0] sp,
      input logic [2:0] da, input logic [2:0] db, input logic [7:0] ar);
    logic [63:0] w = '0;
    w[51:49] = cc; w[48] = sg; w[46:45] = mg; w[42] = ng; w[41:39] = sp;
    w[15:8] = ar; w[5:3] = da; w[2:0] = db;
    return w;
  endfunction

  function automatic logic model_cmp(input logic [2:0] cc, input logic sg,
      input logic slt, input logic ult, input logic eq);
    logic lt = sg ? slt : ult;
    case (cc)
      3'd0: return 1'b0;
      3'd1: return lt;
      3'd2: return eq;
      3'd3: return lt | eq;
      3'd4: return !(lt | eq);
      3'd5: return !eq;
      3'd6: return !lt;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic model_mrg(input logic [1:0] mg, input logic x, input logic p);
    case (mg)
      2'd0: return x & p;
      2'd1: return x | p;
      default: return x ^ p;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [63:0] w, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    issue_valid = 1'b1; issue_insn = w; opnd_a = a; opnd_b = b;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  // write value v into predicate idx: condition never/always, AND with entry 7
  task automatic setp(input logic [2:0] idx, input logic v);
    issue(mk(v ? 3'd7 : 3'd0, 1'b0, 2'd0, 1'b0, 3'd7, idx, 3'd7, 8'd0), 32'd0, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; issue_valid = 1'b0; issue_insn = '0;
    opnd_a = '0; opnd_b = '0; prd_idx = 3'd0;
    repeat (3) @(negedge clk);
    check("R10 ready low in reset", {31'd0, issue_ready}, 32'd0);
    check("R10 done low in reset", {31'd0, done_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 ready after reset", {31'd0, issue_ready}, 32'd1);
    check("R10 done idle", {31'd0, done_o}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      prd_idx = 3'(i); #1;
      check("R6 reset predicate", {31'd0, prd_val}, (i == 7) ? 32'd1 : 32'd0);
    end

    // R9: operand A index follows bits 15:8 without a clock
    issue_insn = mk(3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 3'd0, 8'hA5); #1;
    check("R9 areg index", {24'd0, areg_idx}, 32'hA5);

    // table sweep: R1 R2 R3 R4
    prd_idx = 3'd2;
    for (int v = 0; v < 10; v++) begin
      for (int cc = 0; cc < 8; cc++) begin
        for (int sg = 0; sg < 2; sg++) begin
          for (int mg = 0; mg < 3; mg++) begin
            for (int ng = 0; ng < 2; ng++) begin
              for (int sv = 0; sv < 2; sv++) begin
                logic c, p, ea, eb;
                setp(3'd1, sv[0]);
                c  = model_cmp(3'(cc), sg[0], VEC[v][2], VEC[v][1], VEC[v][0]);
                p  = sv[0] ^ ng[0];
                ea = model_mrg(2'(mg), c, p);
                eb = model_mrg(2'(mg), !c, p);
                issue(mk(3'(cc), sg[0], 2'(mg), ng[0], 3'd1, 3'd2, 3'd3, 8'd0),
                      VEC[v][66:35], VEC[v][34:3]);
                check("R1 R2 R3 R4 merged results and write",
                      {28'd0, done_o, res_a_o, res_b_o, prd_val}, {28'd0, 1'b1, ea, eb, ea});
              end
            end
          end
        end
      end
    end

    // R8: no done in the following idle cycle, prediction held
    @(negedge clk);
    check("R8 done single pulse", {31'd0, done_o}, 32'd0);

    // R6: writes to entry 7 ignored
    issue(mk(3'd0, 1'b0, 2'd0, 1'b0, 3'd7, 3'd7, 3'd7, 8'd0), 32'd0, 32'd0);
    prd_idx = 3'd7; #1;
    check("R6 entry 7 stays true", {31'd0, prd_val}, 32'd1);

    // R7: equal destinations, A side wins
    prd_idx = 3'd4;
    issue(mk(3'd7, 1'b0, 2'd0, 1'b0, 3'd7, 3'd4, 3'd4, 8'd0), 32'd0, 32'd0);
    check("R7 same dest takes A (1)", {31'd0, prd_val}, 32'd1);
    issue(mk(3'd0, 1'b0, 2'd0, 1'b0, 3'd7, 3'd4, 3'd4, 8'd0), 32'd0, 32'd0);
    check("R7 same dest takes A (0)", {31'd0, prd_val}, 32'd0);

    // R5: reserved merge code, no write
    setp(3'd5, 1'b1);
    setp(3'd6, 1'b0);
    check("R5 legal code clears illegal", {31'd0, illegal_o}, 32'd0);
    prd_idx = 3'd5;
    issue(mk(3'd0, 1'b0, 2'd3, 1'b0, 3'd7, 3'd5, 3'd6, 8'd0), 32'd0, 32'd0);
    check("R5 illegal with done", {30'd0, done_o, illegal_o}, 32'd3);
    check("R5 dest A untouched", {31'd0, prd_val}, 32'd1);
    prd_idx = 3'd6; #1;
    check("R5 dest B untouched", {31'd0, prd_val}, 32'd0);

    // R8: back-to-back, second reads first's result as source
    setp(3'd4, 1'b0);
    @(negedge clk);
    issue_valid = 1'b1;
    issue_insn = mk(3'd7, 1'b0, 2'd0, 1'b0, 3'd7, 3'd4, 3'd7, 8'd0);
    @(negedge clk);
    issue_insn = mk(3'd0, 1'b0, 2'd1, 1'b0, 3'd4, 3'd5, 3'd7, 8'd0);
    @(negedge clk);
    issue_valid = 1'b0;
    check("R8 back-to-back forward", {30'd0, done_o, res_a_o}, 32'd3);
    prd_idx = 3'd5; #1;
    check("R8 back-to-back write", {31'd0, prd_val}, 32'd1);

    // R10: reset mid-run clears predicates
    rst_n = 1'b0; #1;
    check("R10 async reset", {30'd0, issue_ready, prd_val}, 32'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule